// File: doc/BRIEF.md
# UART Modem Status and Loopback Unit

This block produces the 8-bit modem status value of a small UART. Its inputs are the active-low modem input pins and the modem control bits. The upper nibble shows the current line states. The lower nibble holds sticky change flags, which are cleared when software reads the status register. An internal loopback switch routes the modem control outputs back into the status bits, so software can exercise the modem logic with no external wiring.

The block raises a level-sensitive modem-status interrupt while any change flag is set and the interrupt enable is on. It also gates the transmitter for automatic CTS flow control. The transmitter requests each new character and reports when that character is done. While the remote end deasserts CTS, the block grants no new character, but it never interrupts a character that is already in progress.

A build parameter selects a pin-reduced package. In that package the DSR, RI and CD pins do not exist and are tied inactive, so their status bits and change flags can move only through loopback.

Top module: `modem_status_unit`

## Requirements
- R1: Outside loopback, status bits 4, 5, 6 and 7 show the inverted CTS, DSR, RI and CD pins. The pins pass through a two-stage synchronizer, so a pin change is visible two clock edges after it is driven.
- R2: In loopback, status bit 4 equals control bit 1, bit 5 equals control bit 0, bit 6 equals control bit 2 and bit 7 equals control bit 3. A control change shows on the status in the same cycle.
- R3: Flag bits 0, 1 and 3 are set on any change of the CTS, DSR and CD status bits respectively, one clock edge after the status bit changes.
- R4: Flag bit 2 is set only when the RI status bit falls from 1 to 0. A rise of RI sets no flag.
- R5: A read strobe clears all flags at the next edge. A flag whose event lands on that same edge stays set. Flags hold their value until a read.
- R6: The interrupt output is high exactly while the enable input is 1 and at least one flag is set.
- R7: With `FULL_PINS_P` = 0, the DSR, RI and CD pins have no effect. Outside loopback, status bits 7..5 and flag bits 3..1 stay 0, and these bits follow control bits 0, 2 and 3 only in loopback.
- R8: With auto-CTS enabled, no character start is granted while the CTS status bit is 0. A character that has been granted completes, and the next grant waits for both its done pulse and CTS being active again.
- R9: With auto-CTS disabled, the transmit grant does not depend on CTS and is withheld only while a character is in progress.
- R10: After reset, the status reads 0x00, the interrupt is low and the transmit grant is high (pins inactive, control bits 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low (unused when pin-reduced) |
| ri_ni | input | 1 | Ring indicator pin, active low (unused when pin-reduced) |
| cd_ni | input | 1 | Carrier detect pin, active low (unused when pin-reduced) |
| mctl_i | input | 4 | Modem control bits: 0 DTR, 1 RTS, 2 OP1, 3 OP2 |
| loop_en_i | input | 1 | Internal loopback enable |
| ms_ie_i | input | 1 | Modem-status interrupt enable |
| auto_cts_i | input | 1 | Automatic CTS flow control enable |
| status_rd_i | input | 1 | One-cycle strobe for a status register read |
| char_start_req_i | input | 1 | Transmitter wants to begin a character |
| char_done_i | input | 1 | Transmitter finished the current character |
| status_o | output | 8 | Status: 7..4 line states CD, RI, DSR, CTS; 3..0 flags CD, RI trailing, DSR, CTS |
| ms_irq_o | output | 1 | Modem-status interrupt, level |
| tx_grant_o | output | 1 | Transmitter may start a character this cycle |

## Verification
The hardest case to reach is an event whose flag is set on the same edge that a read clears the flags. That edge comes three clock edges after the pin is driven, because of the two synchronizer stages and the flag register. The bench drives DSR low, waits exactly two edges, and then raises the read strobe so that it spans the third edge. The pin-reduced variant's CD flag is reached only by switching on loopback and toggling control bit 3. A second instance shares every stimulus, so the same run also shows that its missing pins are ignored.

// File: rtl/msu_pkg.sv
package msu_pkg;
  localparam int unsigned NLINES = 4;
  // line index = flag bit; status bit = index + NLINES
  localparam int unsigned IDX_CTS = 0;
  localparam int unsigned IDX_DSR = 1;
  localparam int unsigned IDX_RI  = 2;
  localparam int unsigned IDX_CD  = 3;
  typedef logic [NLINES-1:0] line_vec_t;
endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1; // inactive level of active-low pins
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/msu_delta.sv
module msu_delta
  import msu_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_vec_t cur_i,
  input  logic      rd_i,
  output line_vec_t delta_o
);
  line_vec_t prev_q, hit, delta_q;

  for (genvar i = 0; i < NLINES; i++) begin : g_hit
    if (i == IDX_RI) begin : g_trail
      assign hit[i] = prev_q[i] & ~cur_i[i];
    end else begin : g_any
      assign hit[i] = prev_q[i] ^ cur_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= cur_i;
      delta_q <= hit | (delta_q & {NLINES{~rd_i}});
    end
  end

  assign delta_o = delta_q;

  p_flag_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
  p_read_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && cur_i == prev_q) |=> delta_q == '0);
  p_ri_trailing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(delta_q[IDX_RI]) |-> ($past(prev_q[IDX_RI]) && !$past(cur_i[IDX_RI])));
endmodule

// File: rtl/msu_flow.sv
module msu_flow (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_en_i,
  input  logic cts_ok_i,
  input  logic start_req_i,
  input  logic done_i,
  output logic grant_o
);
  logic busy_q;

  assign grant_o = ~busy_q & (~auto_en_i | cts_ok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      busy_q <= 1'b0;
    else if (done_i)                  busy_q <= 1'b0;
    else if (start_req_i && grant_o)  busy_q <= 1'b1;
  end

  // a granted character is never cut short by CTS
  p_char_completes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> busy_q);
  p_one_at_a_time_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && start_req_i && !done_i) |=> !grant_o);
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
#(
  parameter bit          FULL_PINS_P = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cts_ni,
  input  logic       dsr_ni,
  input  logic       ri_ni,
  input  logic       cd_ni,
  input  logic [3:0] mctl_i,
  input  logic       loop_en_i,
  input  logic       ms_ie_i,
  input  logic       auto_cts_i,
  input  logic       status_rd_i,
  input  logic       char_start_req_i,
  input  logic       char_done_i,
  output logic [7:0] status_o,
  output logic       ms_irq_o,
  output logic       tx_grant_o
);
  line_vec_t pin_raw, pin_s, loop_v, live, delta;

  if (FULL_PINS_P) begin : g_full
    assign pin_raw = {cd_ni, ri_ni, dsr_ni, cts_ni};
  end else begin : g_lite
    assign pin_raw = {3'b111, cts_ni};
  end

  msu_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_raw), .q_o(pin_s)
  );

  // loopback routing: RTS->CTS, DTR->DSR, OP1->RI, OP2->CD
  always_comb begin
    loop_v          = '0;
    loop_v[IDX_CTS] = mctl_i[1];
    loop_v[IDX_DSR] = mctl_i[0];
    loop_v[IDX_RI]  = mctl_i[2];
    loop_v[IDX_CD]  = mctl_i[3];
  end

  assign live = loop_en_i ? loop_v : ~pin_s;

  msu_delta u_delta (
    .clk_i, .rst_ni, .cur_i(live), .rd_i(status_rd_i), .delta_o(delta)
  );

  msu_flow u_flow (
    .clk_i, .rst_ni,
    .auto_en_i(auto_cts_i),
    .cts_ok_i(live[IDX_CTS]),
    .start_req_i(char_start_req_i),
    .done_i(char_done_i),
    .grant_o(tx_grant_o)
  );

  assign status_o = {live, delta};
  assign ms_irq_o = ms_ie_i & (|delta);

  p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ms_irq_o && !status_rd_i && ms_ie_i) |=> (ms_irq_o || !ms_ie_i));
  p_cts_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_en_i && $past(!loop_en_i) && !$stable(status_o[4]))
      |-> (status_o[4] == !$past(cts_ni, 2)));

  if (!FULL_PINS_P) begin : g_lite_chk
    p_lite_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !loop_en_i |-> status_o[7:5] == 3'b000);
  end
endmodule

// File: tb/test_modem_status_unit.sv
module test_modem_status_unit;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic [3:0] mctl = '0;
  logic loop_en = 1'b0, ie = 1'b1, auto_cts = 1'b0, rd = 1'b0;
  logic req = 1'b0, done = 1'b0;
  logic [7:0] st_full, st_lite;
  logic irq_full, irq_lite, grant_full, grant_lite;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  modem_status_unit #(.FULL_PINS_P(1'b1)) i_modem_status_unit (
    .clk_i(clk), .rst_ni, .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n), .cd_ni(cd_n),
    .mctl_i(mctl), .loop_en_i(loop_en), .ms_ie_i(ie), .auto_cts_i(auto_cts),
    .status_rd_i(rd), .char_start_req_i(req), .char_done_i(done),
    .status_o(st_full), .ms_irq_o(irq_full), .tx_grant_o(grant_full)
  );

  modem_status_unit #(.FULL_PINS_P(1'b0)) i_modem_status_unit_lite (
    .clk_i(clk), .rst_ni, .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n), .cd_ni(cd_n),
    .mctl_i(mctl), .loop_en_i(loop_en), .ms_ie_i(ie), .auto_cts_i(auto_cts),
    .status_rd_i(rd), .char_start_req_i(req), .char_done_i(done),
    .status_o(st_lite), .ms_irq_o(irq_lite), .tx_grant_o(grant_lite)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic rd_pulse();
    rd = 1'b1; step(1); rd = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // {loop, mctl[3:0], pins {cd,ri,dsr,cts}_n, expected status[7:4]}
  localparam logic [12:0] VEC [10] = '{
    {1'b0, 4'b0000, 4'b1111, 4'b0000},
    {1'b0, 4'b0000, 4'b1110, 4'b0001},
    {1'b0, 4'b0000, 4'b0000, 4'b1111},
    {1'b0, 4'b0000, 4'b0111, 4'b1000},
    {1'b1, 4'b0001, 4'b0000, 4'b0010},
    {1'b1, 4'b0010, 4'b0000, 4'b0001},
    {1'b1, 4'b0100, 4'b0000, 4'b0100},
    {1'b1, 4'b1000, 4'b0000, 4'b1000},
    {1'b1, 4'b1011, 4'b0000, 4'b1011},
    {1'b1, 4'b0101, 4'b0000, 4'b0110}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    // R10 reset state
    chk("R10 status", st_full, 8'h00);
    chk("R10 irq", {7'b0, irq_full}, 8'h00);
    chk("R10 grant", {7'b0, grant_full}, 8'h01);

    // R1 / R2 / R7 vector table
    for (int k = 0; k < 10; k++) begin
      loop_en = VEC[k][12];
      mctl    = VEC[k][11:8];
      {cd_n, ri_n, dsr_n, cts_n} = VEC[k][7:4];
      step(3);
      chk(VEC[k][12] ? "R2 loop map" : "R1 pin map", {4'b0, st_full[7:4]}, {4'b0, VEC[k][3:0]});
      chk("R7 lite map", {4'b0, st_lite[7:4]},
          {4'b0, VEC[k][12] ? VEC[k][3:0] : {3'b000, VEC[k][0]}});
    end

    loop_en = 1'b0; mctl = '0; {cd_n, ri_n, dsr_n, cts_n} = 4'b1111;
    step(3);
    rd_pulse();
    chk("R5 cleared", st_full, 8'h00);
    chk("R6 irq low", {7'b0, irq_full}, 8'h00);

    // R1 latency, R3 flag one edge later, R6 irq
    cts_n = 1'b0;
    step(2);
    chk("R1 two edges", st_full, 8'h10);
    step(1);
    chk("R3 cts flag", st_full, 8'h11);
    chk("R6 irq set", {7'b0, irq_full}, 8'h01);
    ie = 1'b0; #1;
    chk("R6 irq masked", {7'b0, irq_full}, 8'h00);
    ie = 1'b1;
    step(1);
    chk("R5 held", st_full, 8'h11);
    rd_pulse();
    chk("R5 read clears", st_full, 8'h10);
    chk("R6 irq after read", {7'b0, irq_full}, 8'h00);

    // R5 event on the read edge survives
    dsr_n = 1'b0;
    step(2);
    rd_pulse();
    chk("R5 same edge kept", st_full, 8'h32);
    rd_pulse();
    chk("R5 second read", st_full, 8'h30);

    // R4 RI trailing edge only
    ri_n = 1'b0; step(3);
    chk("R4 rise no flag", st_full, 8'h70);
    ri_n = 1'b1; step(3);
    chk("R4 fall flag", st_full, 8'h34);
    rd_pulse();

    cts_n = 1'b1; dsr_n = 1'b1; step(3);
    chk("R3 release flags", st_full, 8'h03);
    rd_pulse();

    // R7 missing pins ignored
    dsr_n = 1'b0; ri_n = 1'b0; cd_n = 1'b0; step(3);
    chk("R3 full dsr/cd", st_full, 8'hEA);
    chk("R7 lite ignores pins", st_lite, 8'h00);
    chk("R7 lite no irq", {7'b0, irq_lite}, 8'h00);
    rd_pulse();
    dsr_n = 1'b1; ri_n = 1'b1; cd_n = 1'b1; step(3);
    chk("R4 full ri fall", st_full, 8'h0E);
    rd_pulse();

    // R7 lite CD reached only via loopback
    loop_en = 1'b1; step(1);
    chk("R7 lite loop idle", st_lite, 8'h00);
    mctl = 4'b1000; step(1);
    chk("R7 lite cd flag", st_lite, 8'h88);
    rd_pulse();
    chk("R7 lite read", st_lite, 8'h80);
    mctl = 4'b0000; step(1);
    loop_en = 1'b0; rd_pulse();

    // R8 auto-CTS
    auto_cts = 1'b1; cts_n = 1'b0; step(3); rd_pulse();
    chk("R8 grant cts on", {7'b0, grant_full}, 8'h01);
    req = 1'b1; step(1); req = 1'b0;
    chk("R8 busy", {7'b0, grant_full}, 8'h00);
    cts_n = 1'b1; step(3);
    chk("R8 cts off mid char", {7'b0, grant_full}, 8'h00);
    done = 1'b1; step(1); done = 1'b0;
    chk("R8 hold after done", {7'b0, grant_full}, 8'h00);
    cts_n = 1'b0; step(2);
    chk("R8 resume", {7'b0, grant_full}, 8'h01);

    // R9 auto-CTS off
    auto_cts = 1'b0; cts_n = 1'b1; step(2);
    chk("R9 ignore cts", {7'b0, grant_full}, 8'h01);
    req = 1'b1; step(1); req = 1'b0;
    chk("R9 busy", {7'b0, grant_full}, 8'h00);
    done = 1'b1; step(1); done = 1'b0;
    chk("R9 free", {7'b0, grant_full}, 8'h01);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule